// File: doc/BRIEF.md
# Key-Sequenced Configuration Register Guard

This block sits on a simple synchronous register bus in front of two configuration registers. One register holds the power mode and the core clock divider. The other selects the clock source. Software cannot change either register with a single write. It must write three times in order: a first key, the new data value, and then a second key. Each register has its own fixed pair of key values.

Each register has its own sequence tracker. When the first key is correct, the tracker arms. The data write that follows is held in a shadow register. The value moves into the live register only in the cycle in which the correct second key is written. A write of any other kind between these steps discards the pending value. This includes a wrong key value, a repeated step, or a write to any other address. A rejected or aborted attempt sets a sticky per-register flag, and reading the status location clears it. Read cycles and idle cycles between the steps do not disturb a sequence.

The power register drives two decoded fields: a 3-bit core clock divider and a nap request. A value of 0x78 selects full speed (divider 0). A value of 0x73 requests nap mode with divider 3.

Top module: `keyguard_top`

## Requirements
- R1: After reset the power register reads 0x7B (divider code 3, active mode), the clock-source register reads 0x00 and both reject flags are 0.
- R2: The power register (data at address 0x0) takes a new value only after three consecutive writes: 0x01 to address 0x1, the data to address 0x0, then 0xF4 to address 0x2. The value is not visible after the data write. It appears in the cycle after the edge of the 0xF4 write.
- R3: The clock-source register (data at address 0x4) takes a new value only after three consecutive writes: 0xAA to address 0x5, the data to address 0x4, then 0x55 to address 0x6. The value appears in the cycle after the edge of the 0x55 write.
- R4: Idle cycles and read cycles placed between the steps of a sequence do not break it.
- R5: A wrong key value discards the sequence and leaves the register unchanged. A wrong value at the first-key address also counts, and so does a wrong value at the second-key address after the data write. In both cases the reject flag of that register is set.
- R6: While a sequence is in progress, a write to any address other than the expected next one aborts it. The register stays unchanged and its reject flag is set. A second key written afterwards does not commit.
- R7: A write to a data, first-key or second-key address that does not continue a sequence is rejected. The register is unchanged and its reject flag is set.
- R8: A read of address 0x8 returns the reject flags: bit 0 for the power register, bit 1 for the clock-source register, all other bits 0. The read clears the flags for the next cycle. A reject in the same cycle as the read keeps its bit set.
- R9: The core divider output equals bits [2:0] of the power register. The nap output is 1 exactly when bits [6:3] equal 4'b1110. Writing 0x78 gives divider 0 with nap 0, and writing 0x73 gives divider 3 with nap 1.
- R10: Read data is combinational while the read strobe is high. Addresses 0x0 and 0x4 return the live values. Key addresses, unmapped addresses and cycles with no read return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Register address shared by read and write |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational |
| pwr_ctrl | output | DATA_W | Live power/divider register |
| core_div | output | 3 | Decoded core clock divider code |
| nap_req | output | 1 | Decoded nap-mode request |
| clk_src_ctrl | output | DATA_W | Live clock-source register |
| rej_flags | output | 2 | Sticky reject flags (bit 0 power, bit 1 clock source) |

## Verification
The bench builds the block with its default parameters: a 4-bit address and 8-bit data. With these values, every mapped location can be driven from the bus, as well as unmapped ones such as 0xC and 0xF. The directed tasks cover the following cases:
- each register's full key sequence;
- sequences stretched by idle and read cycles;
- wrong keys at either key address;
- foreign writes in the middle of a sequence;
- a data write with no key before it;
- a status read that coincides with an abort, so that setting the flag has to win over clearing it.

// File: rtl/keyguard_pkg.sv
package keyguard_pkg;

    localparam int NREG        = 2;
    localparam int REG_PWR     = 0;
    localparam int REG_CLK     = 1;
    localparam int SLOT_DATA   = 0;
    localparam int SLOT_KEY1   = 1;
    localparam int SLOT_KEY2   = 2;
    localparam int REG_STRIDE  = 4;
    localparam int STATUS_ADDR = 8;
    localparam int DIV_W       = 3;

    localparam logic [3:0] MODE_NAP = 4'b1110;

    typedef enum logic [1:0] {
        TK_IDLE   = 2'd0,
        TK_ARMED  = 2'd1,
        TK_LOADED = 2'd2
    } tk_state_e;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             nap;
    } pwr_decode_t;

    function automatic int slot_addr(input int reg_idx, input int slot);
        return reg_idx * REG_STRIDE + slot;
    endfunction

    function automatic logic [7:0] first_key(input int reg_idx);
        return (reg_idx == REG_PWR) ? 8'h01 : 8'hAA;
    endfunction

    function automatic logic [7:0] second_key(input int reg_idx);
        return (reg_idx == REG_PWR) ? 8'hF4 : 8'h55;
    endfunction

    function automatic logic [7:0] reset_value(input int reg_idx);
        return (reg_idx == REG_PWR) ? 8'h7B : 8'h00;
    endfunction

endpackage

// File: rtl/kg_tracker.sv
module kg_tracker
    import keyguard_pkg::*;
#(
    parameter int              ADDR_W  = 4,
    parameter int              DATA_W  = 8,
    parameter int              A_DATA  = 0,
    parameter int              A_KEY1  = 1,
    parameter int              A_KEY2  = 2,
    parameter logic [DATA_W-1:0] KEY1    = '0,
    parameter logic [DATA_W-1:0] KEY2    = '0,
    parameter logic [DATA_W-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] live_q,
    output logic              reject_o
);

    localparam logic [ADDR_W-1:0] ADR_D  = ADDR_W'(A_DATA);
    localparam logic [ADDR_W-1:0] ADR_K1 = ADDR_W'(A_KEY1);
    localparam logic [ADDR_W-1:0] ADR_K2 = ADDR_W'(A_KEY2);

    tk_state_e         state_q, state_d;
    logic [DATA_W-1:0] shadow_q;
    logic              hit_d, hit_k1, hit_k2, own_hit;
    logic              key1_ok, key2_ok;
    logic              capture, commit;

    assign hit_d   = wr_en && (wr_addr == ADR_D);
    assign hit_k1  = wr_en && (wr_addr == ADR_K1);
    assign hit_k2  = wr_en && (wr_addr == ADR_K2);
    assign own_hit = hit_d || hit_k1 || hit_k2;
    assign key1_ok = hit_k1 && (wr_data == KEY1);
    assign key2_ok = hit_k2 && (wr_data == KEY2);

    always_comb begin
        state_d  = state_q;
        capture  = 1'b0;
        commit   = 1'b0;
        reject_o = 1'b0;
        if (wr_en) begin
            unique case (state_q)
                TK_IDLE: begin
                    if (key1_ok) begin
                        state_d = TK_ARMED;
                    end else if (own_hit) begin
                        reject_o = 1'b1;
                    end
                end
                TK_ARMED: begin
                    if (hit_d) begin
                        capture = 1'b1;
                        state_d = TK_LOADED;
                    end else begin
                        reject_o = 1'b1;
                        state_d  = TK_IDLE;
                    end
                end
                TK_LOADED: begin
                    if (key2_ok) begin
                        commit = 1'b1;
                    end else begin
                        reject_o = 1'b1;
                    end
                    state_d = TK_IDLE;
                end
                default: state_d = TK_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= TK_IDLE;
            shadow_q <= '0;
            live_q   <= RST_VAL;
        end else begin
            state_q <= state_d;
            if (capture) shadow_q <= wr_data;
            if (commit)  live_q   <= shadow_q;
        end
    end

    // R2 / R3: the live value only moves after a correct second key in the loaded state
    a_r2_commit_needs_key2 : assert property (@(posedge clk) disable iff (rst)
        (live_q != $past(live_q)) |->
            $past(state_q == TK_LOADED && wr_en && wr_addr == ADR_K2 && wr_data == KEY2));

    // R7: a data write with no armed sequence leaves the register alone
    a_r7_idle_data_ignored : assert property (@(posedge clk) disable iff (rst)
        (state_q == TK_IDLE && hit_d) |=> ($stable(live_q) && state_q == TK_IDLE));

    // R6: a foreign write while armed drops back to idle
    a_r6_foreign_aborts : assert property (@(posedge clk) disable iff (rst)
        (state_q == TK_ARMED && wr_en && !hit_d) |=> (state_q == TK_IDLE && $stable(live_q)));

    // R4: cycles without a write keep the tracker where it is
    a_r4_hold_without_write : assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(state_q));

endmodule

// File: rtl/kg_status.sv
module kg_status
    import keyguard_pkg::*;
#(
    parameter int N = NREG
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] reject_i,
    input  logic         clear_i,
    output logic [N-1:0] flags_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else if (clear_i) begin
            flags_q <= reject_i;
        end else begin
            flags_q <= flags_q | reject_i;
        end
    end

    // R8: a reject always lands in the flags, even during a clearing read
    a_r8_set_wins : assert property (@(posedge clk) disable iff (rst)
        (|reject_i) |=> ((flags_q & $past(reject_i)) == $past(reject_i)));

    // R8: without a clear, flags never drop
    a_r8_sticky : assert property (@(posedge clk) disable iff (rst)
        !clear_i |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

endmodule

// File: rtl/kg_decode.sv
module kg_decode
    import keyguard_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] pwr_value,
    output pwr_decode_t       dec
);

    always_comb begin
        dec.div = pwr_value[DIV_W-1:0];
        dec.nap = (pwr_value[6:3] == MODE_NAP);
    end

endmodule

// File: rtl/keyguard_top.sv
module keyguard_top
    import keyguard_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] pwr_ctrl,
    output logic [DIV_W-1:0]  core_div,
    output logic              nap_req,
    output logic [DATA_W-1:0] clk_src_ctrl,
    output logic [NREG-1:0]   rej_flags
);

    localparam logic [ADDR_W-1:0] ADR_STATUS = ADDR_W'(STATUS_ADDR);

    logic [DATA_W-1:0] live   [NREG];
    logic [NREG-1:0]   reject;
    logic              status_rd;
    pwr_decode_t       pdec;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        kg_tracker #(
            .ADDR_W  (ADDR_W),
            .DATA_W  (DATA_W),
            .A_DATA  (slot_addr(g, SLOT_DATA)),
            .A_KEY1  (slot_addr(g, SLOT_KEY1)),
            .A_KEY2  (slot_addr(g, SLOT_KEY2)),
            .KEY1    (DATA_W'(first_key(g))),
            .KEY2    (DATA_W'(second_key(g))),
            .RST_VAL (DATA_W'(reset_value(g)))
        ) u_trk (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (bus_wr),
            .wr_addr  (bus_addr),
            .wr_data  (bus_wdata),
            .live_q   (live[g]),
            .reject_o (reject[g])
        );
    end

    assign status_rd = bus_rd && (bus_addr == ADR_STATUS);

    kg_status #(.N(NREG)) u_status (
        .clk      (clk),
        .rst      (rst),
        .reject_i (reject),
        .clear_i  (status_rd),
        .flags_q  (rej_flags)
    );

    kg_decode #(.DATA_W(DATA_W)) u_dec (
        .pwr_value (live[REG_PWR]),
        .dec       (pdec)
    );

    assign pwr_ctrl     = live[REG_PWR];
    assign clk_src_ctrl = live[REG_CLK];
    assign core_div     = pdec.div;
    assign nap_req      = pdec.nap;

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (status_rd) begin
                bus_rdata = DATA_W'(rej_flags);
            end else begin
                for (int i = 0; i < NREG; i++) begin
                    if (bus_addr == ADDR_W'(slot_addr(i, SLOT_DATA))) bus_rdata = live[i];
                end
            end
        end
    end

    // R10: nothing is driven on the read bus without a read strobe
    a_r10_idle_bus_quiet : assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> (bus_rdata == '0));

    // R1: both registers are back at their reset values right after reset
    a_r1_reset_values : assert property (@(posedge clk)
        $past(rst) |-> (pwr_ctrl == DATA_W'(8'h7B) && clk_src_ctrl == '0 && rej_flags == '0));

endmodule

// File: tb/keyguard_top_tb.sv
module keyguard_top_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata, pwr_ctrl, clk_src_ctrl;
    logic [2:0] core_div;
    logic       nap_req;
    logic [1:0] rej_flags;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    keyguard_top u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwr_ctrl(pwr_ctrl), .core_div(core_div), .nap_req(nap_req),
        .clk_src_ctrl(clk_src_ctrl), .rej_flags(rej_flags)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input int exp, input string req);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 chk(req, bus_rdata, exp);
        @(posedge clk);
        #1 bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic t_reset;
        chk("R1 pwr reset", pwr_ctrl, 8'h7B);
        chk("R1 clk reset", clk_src_ctrl, 8'h00);
        chk("R1 flags reset", rej_flags, 0);
        chk("R9 reset divider", core_div, 3);
        chk("R9 reset nap", nap_req, 0);
        chk("R10 idle rdata", bus_rdata, 0);
        rd_chk(4'h0, 8'h7B, "R10 pwr readback");
        rd_chk(4'h8, 0, "R8 status after reset");
    endtask

    task automatic t_pwr_commit;
        wr(4'h1, 8'h01);
        wr(4'h0, 8'h78);
        chk("R2 not visible before key2", pwr_ctrl, 8'h7B);
        wr(4'h2, 8'hF4);
        chk("R2 committed 0x78", pwr_ctrl, 8'h78);
        chk("R9 full speed divider", core_div, 0);
        chk("R9 full speed nap", nap_req, 0);
        wr(4'h1, 8'h01);
        wr(4'h0, 8'h73);
        wr(4'h2, 8'hF4);
        chk("R2 committed 0x73", pwr_ctrl, 8'h73);
        chk("R9 nap divider", core_div, 3);
        chk("R9 nap request", nap_req, 1);
        chk("R2 no reject flag", rej_flags, 0);
    endtask

    task automatic t_clk_commit;
        wr(4'h5, 8'hAA);
        wr(4'h4, 8'h02);
        chk("R3 not visible before key2", clk_src_ctrl, 8'h00);
        wr(4'h6, 8'h55);
        chk("R3 committed", clk_src_ctrl, 8'h02);
        chk("R3 pwr untouched", pwr_ctrl, 8'h73);
        rd_chk(4'h4, 8'h02, "R10 clk readback");
        rd_chk(4'h5, 0, "R10 key addr reads zero");
        rd_chk(4'hF, 0, "R10 unmapped reads zero");
        chk("R3 no reject flag", rej_flags, 0);
    endtask

    task automatic t_gaps;
        wr(4'h5, 8'hAA);
        idle(3);
        rd_chk(4'h0, 8'h73, "R4 read between steps");
        wr(4'h4, 8'h04);
        idle(2);
        rd_chk(4'h4, 8'h02, "R4 old value during sequence");
        wr(4'h6, 8'h55);
        chk("R4 commit across gaps", clk_src_ctrl, 8'h04);
        chk("R4 no flag", rej_flags, 0);
    endtask

    task automatic t_wrong_key;
        wr(4'h1, 8'h01);
        wr(4'h0, 8'h55);
        wr(4'h2, 8'hF5);
        chk("R5 wrong key2 no commit", pwr_ctrl, 8'h73);
        chk("R5 wrong key2 flag", rej_flags, 2'b01);
        rd_chk(4'h8, 8'h01, "R8 status shows pwr flag");
        chk("R8 flag cleared after read", rej_flags, 0);
        rd_chk(4'h8, 0, "R8 second read zero");
        wr(4'h5, 8'hAB);
        chk("R5 wrong key1 flag", rej_flags, 2'b10);
        wr(4'h4, 8'h07);
        wr(4'h6, 8'h55);
        chk("R5 wrong key1 no commit", clk_src_ctrl, 8'h04);
        rd_chk(4'h8, 8'h02, "R8 status shows clk flag");
    endtask

    task automatic t_intervene;
        wr(4'h1, 8'h01);
        wr(4'h0, 8'h11);
        wr(4'hC, 8'h00);
        chk("R6 abort flag", rej_flags, 2'b01);
        wr(4'h2, 8'hF4);
        chk("R6 late key2 no commit", pwr_ctrl, 8'h73);
        rd_chk(4'h8, 8'h01, "R6 status");
        wr(4'h5, 8'hAA);
        wr(4'h1, 8'h01);
        chk("R6 foreign key aborts clk", rej_flags, 2'b10);
        wr(4'h0, 8'h22);
        wr(4'h2, 8'hF4);
        chk("R6 other tracker still works", pwr_ctrl, 8'h22);
        chk("R6 clk unchanged", clk_src_ctrl, 8'h04);
        rd_chk(4'h8, 8'h02, "R6 status clk");
    endtask

    task automatic t_nokey;
        wr(4'h4, 8'h40);
        chk("R7 lone data write ignored", clk_src_ctrl, 8'h04);
        chk("R7 lone data write flagged", rej_flags, 2'b10);
        rd_chk(4'h8, 8'h02, "R7 status");
        wr(4'h2, 8'hF4);
        chk("R7 lone key2 ignored", pwr_ctrl, 8'h22);
        chk("R7 lone key2 flagged", rej_flags, 2'b01);
        rd_chk(4'h8, 8'h01, "R7 status pwr");
    endtask

    task automatic t_read_race;
        wr(4'h1, 8'h01);
        @(negedge clk);
        bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = 4'h8; bus_wdata = 8'h00;
        #1 chk("R8 race read returns old flags", bus_rdata, 0);
        @(posedge clk);
        #1 bus_wr = 1'b0; bus_rd = 1'b0;
        chk("R8 set wins over clear", rej_flags, 2'b01);
        rd_chk(4'h8, 8'h01, "R8 race flag readable");
        chk("R8 cleared after plain read", rej_flags, 0);
        chk("R8 pwr unchanged", pwr_ctrl, 8'h22);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_pwr_commit();
        t_clk_commit();
        t_gaps();
        t_wrong_key();
        t_intervene();
        t_nokey();
        t_read_race();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule